// File: doc/BRIEF.md
# Start-Bit Framed Serial Converter Interface

This block is the device-side digital front end of an 8-bit serial analog-to-digital converter. While chip select is low it watches the serial data input. The first high bit it samples opens a frame and becomes the most significant bit of an 8-bit control byte. The block then counts serial-clock edges to run an acquisition window and a short conversion phase. After that it shifts the 8-bit result out on the serial data output, most significant bit first. A parallel sample input stands in for the analog front end. Its value is captured when the acquisition window closes.

Two timing variants are selected per frame by an input: an external-clock mode and an internal-clock mode. They differ in the length of acquisition and in how early a following frame may begin. A new start bit can be accepted while the previous result is still leaving the device. This allows back-to-back conversions as often as once every 10 serial clocks. The captured control byte is exported as-is. Its meaning is left to surrounding logic.

The serial clock arrives already synchronised to the system clock `clk`. The block finds its edges internally. Data input is taken on rising serial-clock edges, and the data output moves on falling serial-clock edges.

Top module: `sadc_serial_if`

## Requirements
- R1: No frame opens while the data input is low, and none opens while chip select is high, whatever the serial clock does. A falling chip-select edge on its own opens no frame: `acq_active` and `ctrl_ready` stay low.
- R2: When the interface is idle, a high data bit sampled on a rising serial edge with chip select low opens a frame and is bit 7 of the control byte. The next seven rising edges fill bits 6 down to 0. After the eighth rising edge `ctrl_byte` holds the byte and `ctrl_ready` is high.
- R3: `acq_active` rises at the fourth falling serial edge of the frame. It stays high for two serial clocks when `int_mode`=0 (external clock) and for four serial clocks when `int_mode`=1 (internal clock). `int_mode` is sampled with the start bit.
- R4: `conv_active` is high for the two serial clocks directly after acquisition ends, with no gap.
- R5: `sample_in` is latched on the falling edge that ends acquisition. Changes after that edge do not affect the result being shifted out.
- R6: Result bit D7 appears on `dout` at the second falling edge after acquisition ends. Bits D6 to D0 follow on the next seven falling edges. Then `dout` returns low. `dout` changes only on falling serial edges or chip-select changes.
- R7: In external-clock mode a new start bit is accepted on the first rising edge after D5 has been driven. The older result keeps shifting out its remaining bits. This gives one conversion every 10 serial clocks.
- R8: In internal-clock mode a new start bit is accepted on the first rising edge after D4 has been driven.
- R9: A high data bit sampled while a result is still ahead of its acceptance point is ignored and opens no frame.
- R10: While chip select is high, `dout_oe` is low. Raising chip select aborts any frame, stops the output shifter and drives `dout` low. The next start bit with chip select low is accepted at once.
- R11: After reset, `dout`, `acq_active`, `conv_active`, `ctrl_ready` and `ctrl_byte` are all zero, and no result is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, synchronous to clk |
| din | input | 1 | Serial data input |
| int_mode | input | 1 | 0 = external-clock timing, 1 = internal-clock timing |
| sample_in | input | 8 | Parallel stand-in for the analog sample |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for dout (tri-state control) |
| ctrl_byte | output | 8 | Last complete control byte |
| ctrl_ready | output | 1 | Control byte of the current frame is complete |
| acq_active | output | 1 | Acquisition window open |
| conv_active | output | 1 | Conversion phase in progress |

## Verification
Two functions can fall in the same cycle: a new frame being opened and the shifting out of the previous result. A start bit is judged on the same rising edge at which the shifter's bit position decides whether it is allowed. The bench provokes this with back-to-back frames in both modes. A high data bit is placed one serial clock before the acceptance point and another exactly on it. The check is whether the old result's tail bits stay intact, and whether the second frame's acquisition window lands exactly where an on-time start predicts. If the early bit were wrongly accepted, the window would move one clock earlier.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic {
        MODE_EXT = 1'b0,
        MODE_INT = 1'b1
    } sadc_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_edges_t;

    localparam int SADC_CTRL_W    = 8;
    localparam int SADC_RES_W     = 8;
    localparam int SADC_ACQ_FIRST = 4;
    localparam int SADC_ACQ_EXT   = 2;
    localparam int SADC_ACQ_INT   = 4;
    localparam int SADC_CONV_LEN  = 2;
    localparam int SADC_EARLY_EXT = 5;
    localparam int SADC_EARLY_INT = 4;
    localparam int SADC_CNT_W     = $clog2(SADC_ACQ_FIRST + SADC_ACQ_INT + SADC_CONV_LEN + 1);

    // falling-edge count at which acquisition closes
    function automatic int acq_stop(sadc_mode_e m);
        return SADC_ACQ_FIRST + ((m == MODE_INT) ? SADC_ACQ_INT : SADC_ACQ_EXT);
    endfunction

    // result bit index after which a following start bit is allowed
    function automatic int early_idx(sadc_mode_e m);
        return (m == MODE_INT) ? SADC_EARLY_INT : SADC_EARLY_EXT;
    endfunction

endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det
    import sadc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sclk,
    output sclk_edges_t edges
);

    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    always_comb begin
        edges.rise = !cs_n && sclk && !sclk_q;
        edges.fall = !cs_n && !sclk && sclk_q;
    end

endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
    import sadc_pkg::*;
#(
    parameter int CTRL_W = SADC_CTRL_W,
    parameter int RES_W  = SADC_RES_W,
    parameter int CNT_W  = SADC_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  sclk_edges_t       edges,
    input  logic              din,
    input  logic              int_mode,
    input  logic              start_ok,
    input  logic [RES_W-1:0]  sample_in,
    output logic              frame_active,
    output logic [CTRL_W-1:0] ctrl_byte,
    output logic              ctrl_ready,
    output logic              acq_active,
    output logic              conv_active,
    output logic              load,
    output logic [RES_W-1:0]  result,
    output sadc_mode_e        frame_mode
);

    logic [CNT_W-1:0]  ecnt_q;
    logic [CTRL_W-1:0] ctrl_sh_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [RES_W-1:0]  result_q;
    logic              active_q;
    logic              ready_q;
    sadc_mode_e        mode_q;
    logic              start;
    int                stop_cnt;
    int                next_cnt;

    always_comb begin
        stop_cnt = acq_stop(mode_q);
        next_cnt = int'(ecnt_q) + 1;
        start    = edges.rise && din && !active_q && start_ok;
        load     = active_q && edges.fall && (next_cnt == stop_cnt + SADC_CONV_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ecnt_q    <= '0;
            ctrl_sh_q <= '0;
            ctrl_q    <= '0;
            result_q  <= '0;
            active_q  <= 1'b0;
            ready_q   <= 1'b0;
            mode_q    <= MODE_EXT;
        end else if (cs_n) begin
            active_q <= 1'b0;
            ready_q  <= 1'b0;
        end else if (start) begin
            active_q  <= 1'b1;
            ready_q   <= 1'b0;
            ecnt_q    <= '0;
            mode_q    <= sadc_mode_e'(int_mode);
            ctrl_sh_q <= CTRL_W'(1);
        end else if (active_q) begin
            if (edges.rise && int'(ecnt_q) <= CTRL_W - 1) begin
                ctrl_sh_q <= {ctrl_sh_q[CTRL_W-2:0], din};
                if (int'(ecnt_q) == CTRL_W - 1) begin
                    ctrl_q  <= {ctrl_sh_q[CTRL_W-2:0], din};
                    ready_q <= 1'b1;
                end
            end
            if (edges.fall) begin
                ecnt_q <= ecnt_q + 1'b1;
                if (next_cnt == stop_cnt)
                    result_q <= sample_in;
                if (next_cnt == stop_cnt + SADC_CONV_LEN)
                    active_q <= 1'b0;
            end
        end
    end

    assign frame_active = active_q;
    assign ctrl_byte    = ctrl_q;
    assign ctrl_ready   = ready_q;
    assign acq_active   = active_q && int'(ecnt_q) >= SADC_ACQ_FIRST && int'(ecnt_q) < stop_cnt;
    assign conv_active  = active_q && int'(ecnt_q) >= stop_cnt;
    assign result       = result_q;
    assign frame_mode   = mode_q;

endmodule

// File: rtl/sadc_result_shifter.sv
module sadc_result_shifter
    import sadc_pkg::*;
#(
    parameter int RES_W = SADC_RES_W,
    parameter int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             fall,
    input  logic             load,
    input  logic [RES_W-1:0] load_val,
    input  sadc_mode_e       load_mode,
    output logic             dout,
    output logic             start_ok
);

    logic [RES_W-1:0] sh_q;
    logic [IDX_W-1:0] idx_q;
    logic             busy_q;
    sadc_mode_e       mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
            mode_q <= MODE_EXT;
        end else if (cs_n) begin
            sh_q   <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            sh_q   <= load_val;
            idx_q  <= IDX_W'(RES_W - 1);
            busy_q <= 1'b1;
            mode_q <= load_mode;
        end else if (fall && busy_q) begin
            if (idx_q == '0) begin
                busy_q <= 1'b0;
                sh_q   <= '0;
            end else begin
                sh_q  <= {sh_q[RES_W-2:0], 1'b0};
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    assign dout     = busy_q && sh_q[RES_W-1];
    assign start_ok = !busy_q || (int'(idx_q) <= early_idx(mode_q));

endmodule

// File: rtl/sadc_serial_if.sv
module sadc_serial_if
    import sadc_pkg::*;
#(
    parameter int CTRL_W = SADC_CTRL_W,
    parameter int RES_W  = SADC_RES_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              int_mode,
    input  logic [RES_W-1:0]  sample_in,
    output logic              dout,
    output logic              dout_oe,
    output logic [CTRL_W-1:0] ctrl_byte,
    output logic              ctrl_ready,
    output logic              acq_active,
    output logic              conv_active
);

    sclk_edges_t      edges;
    logic             sclk_rise;
    logic             sclk_fall;
    logic             frame_active;
    logic             start_ok;
    logic             load;
    logic [RES_W-1:0] result;
    sadc_mode_e       frame_mode;

    sadc_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .edges (edges)
    );

    assign sclk_rise = edges.rise;
    assign sclk_fall = edges.fall;

    sadc_frame_seq #(
        .CTRL_W (CTRL_W),
        .RES_W  (RES_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cs_n         (cs_n),
        .edges        (edges),
        .din          (din),
        .int_mode     (int_mode),
        .start_ok     (start_ok),
        .sample_in    (sample_in),
        .frame_active (frame_active),
        .ctrl_byte    (ctrl_byte),
        .ctrl_ready   (ctrl_ready),
        .acq_active   (acq_active),
        .conv_active  (conv_active),
        .load         (load),
        .result       (result),
        .frame_mode   (frame_mode)
    );

    sadc_result_shifter #(
        .RES_W (RES_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .fall      (sclk_fall),
        .load      (load),
        .load_val  (result),
        .load_mode (frame_mode),
        .dout      (dout),
        .start_ok  (start_ok)
    );

    assign dout_oe = !cs_n;

endmodule

// File: rtl/sadc_serial_if_chk.sv
module sadc_serial_if_chk #(
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              din,
    input logic              sclk_rise,
    input logic              sclk_fall,
    input logic              frame_active,
    input logic              acq_active,
    input logic              conv_active,
    input logic              ctrl_ready,
    input logic [CTRL_W-1:0] ctrl_byte,
    input logic              dout
);

    AST_START_NEEDS_HIGH_DIN: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_active) |-> ($past(din) && !$past(cs_n) && $past(sclk_rise))); // R1

    AST_CTRL_MSB_IS_START: assert property (@(posedge clk) disable iff (rst)
        ctrl_ready |-> ctrl_byte[CTRL_W-1]); // R2

    AST_ACQ_OPENS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(acq_active) |-> $past(sclk_fall)); // R3

    AST_CONV_FOLLOWS_ACQ: assert property (@(posedge clk) disable iff (rst)
        ($fell(acq_active) && !cs_n && !$past(cs_n)) |-> conv_active); // R4

    AST_DOUT_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n) && !$past(sclk_fall)) |-> $stable(dout)); // R6

    AST_CS_HIGH_ABORTS: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!frame_active && !dout)); // R10

endmodule

bind sadc_serial_if sadc_serial_if_chk #(.CTRL_W(CTRL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .din          (din),
    .sclk_rise    (sclk_rise),
    .sclk_fall    (sclk_fall),
    .frame_active (frame_active),
    .acq_active   (acq_active),
    .conv_active  (conv_active),
    .ctrl_ready   (ctrl_ready),
    .ctrl_byte    (ctrl_byte),
    .dout         (dout)
);

// File: tb/sadc_serial_if_bench.sv
`timescale 1ns/1ps
module sadc_serial_if_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic       int_mode = 1'b0;
    logic [7:0] sample_in = 8'h00;
    logic       dout, dout_oe, ctrl_ready, acq_active, conv_active;
    logic [7:0] ctrl_byte;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    sadc_serial_if u_sadc_serial_if (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .din         (din),
        .int_mode    (int_mode),
        .sample_in   (sample_in),
        .dout        (dout),
        .dout_oe     (dout_oe),
        .ctrl_byte   (ctrl_byte),
        .ctrl_ready  (ctrl_ready),
        .acq_active  (acq_active),
        .conv_active (conv_active)
    );

    // {mode, control bits 6..0, sample}
    localparam logic [15:0] VEC [6] = '{
        {1'b0, 7'h35, 8'hA5},
        {1'b0, 7'h00, 8'hFF},
        {1'b1, 7'h7F, 8'h3C},
        {1'b1, 7'h2A, 8'h81},
        {1'b0, 7'h51, 8'h00},
        {1'b1, 7'h0F, 8'h5A}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic d);
        din = d;
        @(negedge clk) sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_frame(input logic m, input logic [6:0] c7, input logic [7:0] s);
        int ae;
        ae = m ? 8 : 6;
        int_mode  = m;
        sample_in = s;
        for (int k = 1; k <= ae + 10; k++) begin
            logic d;
            int   exp_d;
            d = (k == 1) ? 1'b1 : ((k <= 8) ? c7[8-k] : 1'b0);
            tick(d);
            if (k == ae) sample_in = ~s;
            check("R3 acq window", int'(acq_active), int'(k >= 4 && k < ae));
            check("R4 conv phase", int'(conv_active), int'(k >= ae && k < ae + 2));
            exp_d = (k >= ae + 2 && k <= ae + 9) ? int'(s[ae+9-k]) : 0;
            check("R5 R6 dout bit", int'(dout), exp_d);
            if (k == 8) begin
                check("R2 ctrl ready", int'(ctrl_ready), 1);
                check("R2 ctrl byte", int'(ctrl_byte), int'({1'b1, c7}));
            end
        end
    endtask

    task automatic run_overlap(input logic m, input logic [6:0] ca, input logic [7:0] sa,
                               input logic [6:0] cb, input logic [7:0] sb);
        int ae, acc, tot;
        string tag;
        ae  = m ? 8 : 6;
        acc = ae + 10 - (m ? 4 : 5);
        tot = acc - 1 + ae + 10;
        tag = m ? "R8" : "R7";
        int_mode  = m;
        sample_in = sa;
        for (int k = 1; k <= tot; k++) begin
            logic d;
            int   kb, exp_d, exp_a;
            kb = k - acc + 1;
            if (k == 1 || k == acc - 1 || k == acc) d = 1'b1;
            else if (k >= 2 && k <= 8) d = ca[8-k];
            else if (k > acc && k <= acc + 7) d = cb[acc+7-k];
            else d = 1'b0;
            tick(d);
            if (k == ae) sample_in = sb;
            if (kb == ae) sample_in = ~sb;
            exp_a = int'((k >= 4 && k < ae) || (kb >= 4 && kb < ae));
            check("R9 acq placement", int'(acq_active), exp_a);
            if (k >= ae + 2 && k <= ae + 9) exp_d = int'(sa[ae+9-k]);
            else if (kb >= ae + 2 && kb <= ae + 9) exp_d = int'(sb[ae+9-kb]);
            else exp_d = 0;
            check({tag, " overlapped dout"}, int'(dout), exp_d);
            if (kb == 8) check({tag, " second ctrl byte"}, int'(ctrl_byte), int'({1'b1, cb}));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R11 reset state
        check("R11 dout", int'(dout), 0);
        check("R11 dout_oe", int'(dout_oe), 0);
        check("R11 acq", int'(acq_active), 0);
        check("R11 conv", int'(conv_active), 0);
        check("R11 ctrl", int'({ctrl_ready, ctrl_byte}), 0);

        // R1: serial clocks with data high but chip select high
        for (int i = 0; i < 3; i++) tick(1'b1);
        check("R1 cs high no frame", int'({acq_active, ctrl_ready}), 0);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 oe with cs low", int'(dout_oe), 1);
        for (int i = 0; i < 12; i++) begin
            tick(1'b0);
            check("R1 low din no frame", int'({acq_active, conv_active, ctrl_ready, dout}), 0);
        end

        // table walk
        for (int i = 0; i < 6; i++) run_frame(VEC[i][15], VEC[i][14:8], VEC[i][7:0]);

        // overlapped frames in both modes
        run_overlap(1'b0, 7'h4B, 8'hC3, 7'h12, 8'h96);
        tick(1'b0);
        run_overlap(1'b1, 7'h66, 8'hE1, 7'h01, 8'h4D);
        tick(1'b0);

        // R10 abort while result bit D6 is on the output
        int_mode  = 1'b0;
        sample_in = 8'hFF;
        tick(1'b1);
        for (int k = 2; k <= 9; k++) tick(1'b0);
        check("R10 D6 before abort", int'(dout), 1);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 oe off", int'(dout_oe), 0);
        check("R10 idle after abort", int'({acq_active, conv_active, ctrl_ready}), 0);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 dout cleared", int'(dout), 0);
        run_frame(1'b0, 7'h33, 8'h6E);

        finish_run();
    end

endmodule